// File: doc/BRIEF.md
# SIMT Branch Divergence Reconvergence Stack

This block keeps the control-flow state of one SIMD wavefront. A stack of entries, each made of a program counter, a reconvergence PC and a lane mask, describes which lanes run which path. The top entry is the state in force: it gives the wavefront's current PC, the PC at which its lanes rejoin, the active lane mask and that mask's lane count.

A sequencer issues one branch command per cycle. An unconditional branch either moves the top PC or, when it reaches the top's reconvergence point, retires the top entry. A conditional branch retires the top entry and pushes up to three new ones: one for the join point, one for the lanes that fall through, and one for the lanes that take the branch. It supplies the target, the fall-through address, the immediate post-dominator and a per-lane condition vector. Pushes that would be useless are skipped, and the taken path ends up on top so it runs first. Each command updates the stack in a single cycle. The result appears on the outputs one cycle after the command is accepted.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds exactly one entry: PC = START_PC, reconvergence PC all ones, mask all ones. All three flags are low.
- R2: An unconditional branch whose target equals the top reconvergence PC removes the top entry, so the stack depth drops by one.
- R3: Any other unconditional branch writes the target into the top PC and leaves the top reconvergence PC, the top mask and the depth unchanged.
- R4: A conditional branch first removes the top entry, which becomes the saved entry. If the saved reconvergence PC differs from the post-dominator, it then pushes {PC = post-dominator, reconvergence = saved reconvergence PC, mask = saved mask}.
- R5: The taken mask is the condition vector ANDed with the saved mask. A not-taken entry {fall-through, post-dominator, saved mask AND NOT taken mask} is pushed only when the fall-through differs from the post-dominator and the taken mask has fewer set lanes than the saved mask.
- R6: A taken entry {target, post-dominator, taken mask} is pushed only when the target differs from the post-dominator and the taken mask is non-zero. It is pushed last, so it ends up on top.
- R7: branchErr is high for one cycle after an accepted conditional branch that either has target equal to fall-through or leaves a top PC equal to the saved PC. The stack update is still applied.
- R8: If a conditional branch would leave more than DEPTH entries, overflowFlag is high for one cycle and the stack is unchanged.
- R9: Any command issued while the stack is empty raises underflowFlag for one cycle and leaves the stack empty.
- R10: activeLanes equals the number of set bits in curMask. While the stack is empty, curPc, curRpc and curMask are all zero.
- R11: cmdReady is always high. Every cycle with cmdValid high applies one command, visible on the next cycle. Cycles without cmdValid leave all state unchanged and the flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Branch command present |
| cmdReady | output | 1 | Command accepted (always high) |
| cmdCond | input | 1 | 1 = conditional branch, 0 = unconditional |
| cmdTarget | input | PC_W | Branch target PC |
| cmdFallThru | input | PC_W | Address of the next sequential instruction |
| cmdPostDom | input | PC_W | Immediate post-dominator PC |
| cmdLaneCond | input | LANES | Per-lane branch condition |
| curPc | output | PC_W | Top entry PC |
| curRpc | output | PC_W | Top entry reconvergence PC |
| curMask | output | LANES | Top entry active mask |
| activeLanes | output | $clog2(LANES+1) | Set lanes in curMask |
| stackDepth | output | $clog2(DEPTH+1) | Number of valid entries |
| overflowFlag | output | 1 | Command rejected: capacity exceeded |
| underflowFlag | output | 1 | Command rejected: stack empty |
| branchErr | output | 1 | Malformed conditional branch seen |

## Verification
The assertions check the invariants that can be seen on any single cycle:
- the depth bound;
- that a rejected command leaves the depth where it was;
- that an unconditional branch changes the depth by at most one;
- that a conditional branch grows it by at most two;
- that the lane count matches the mask;
- that an empty stack drives zeros.

Whether a conditional branch skips the right pushes, orders them with the taken path on top, and forms the not-taken mask correctly only shows up when the bench's reference model runs crafted and random branch sequences and compares every output on every cycle.

// File: rtl/simt_rcs_pkg.sv
package simt_rcs_pkg;

  // Control-to-datapath strobes for one accepted command
  typedef struct packed {
    logic commit;
    logic popTop;
    logic replacePc;
    logic pushRecon;
    logic pushNotTaken;
    logic pushTaken;
  } rcs_strobe_t;

endpackage

// File: rtl/rcs_popcount.sv
module rcs_popcount #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import simt_rcs_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LCNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdCond,
  input  logic [PC_W-1:0]   cmdTarget,
  input  logic [PC_W-1:0]   cmdFallThru,
  input  logic [PC_W-1:0]   cmdPostDom,
  input  logic [LANES-1:0]  cmdLaneCond,
  input  logic [PC_W-1:0]   topPc,
  input  logic [PC_W-1:0]   topRpc,
  input  logic [LANES-1:0]  topMask,
  input  logic [PC_W-1:0]   belowPc,
  input  logic              belowValid,
  input  logic [CNT_W-1:0]  stackDepth,
  output rcs_strobe_t       strobe,
  output logic [LANES-1:0]  takenMask,
  output logic [LCNT_W-1:0] topCount,
  output logic              overflowQ,
  output logic              underflowQ,
  output logic              errQ
);
  logic [LCNT_W-1:0] takenCount;
  logic topValid, wantRecon, wantNt, wantTk;
  logic ovflNext, unflNext, errNext, commit;
  logic [PC_W-1:0] newTopPc;
  logic newTopValid;
  int pushCnt, resultDepth;

  assign takenMask = cmdLaneCond & topMask;

  rcs_popcount #(.W(LANES), .CW(LCNT_W)) topPop_i   (.vec(topMask),   .count(topCount));
  rcs_popcount #(.W(LANES), .CW(LCNT_W)) takenPop_i (.vec(takenMask), .count(takenCount));

  always_comb begin
    topValid  = (stackDepth != '0);
    wantRecon = (topRpc != cmdPostDom);
    wantNt    = (cmdFallThru != cmdPostDom) && (takenCount < topCount);
    wantTk    = (cmdTarget != cmdPostDom) && (takenCount != '0);
    pushCnt   = int'(wantRecon) + int'(wantNt) + int'(wantTk);
    resultDepth = int'(stackDepth) - 1 + pushCnt;

    unflNext = cmdValid && !topValid;
    ovflNext = cmdValid && topValid && cmdCond && (resultDepth > DEPTH);
    commit   = cmdValid && !unflNext && !ovflNext;

    strobe.commit       = commit;
    strobe.popTop       = commit && (cmdCond || (cmdTarget == topRpc));
    strobe.replacePc    = commit && !cmdCond && (cmdTarget != topRpc);
    strobe.pushRecon    = commit && cmdCond && wantRecon;
    strobe.pushNotTaken = commit && cmdCond && wantNt;
    strobe.pushTaken    = commit && cmdCond && wantTk;

    if (wantTk)         newTopPc = cmdTarget;
    else if (wantNt)    newTopPc = cmdFallThru;
    else if (wantRecon) newTopPc = cmdPostDom;
    else                newTopPc = belowPc;
    newTopValid = (pushCnt > 0) || belowValid;

    errNext = commit && cmdCond &&
              ((cmdTarget == cmdFallThru) || (newTopValid && (newTopPc == topPc)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowQ  <= 1'b0;
      underflowQ <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      overflowQ  <= ovflNext;
      underflowQ <= unflNext;
      errQ       <= errNext;
    end
  end
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import simt_rcs_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  parameter logic [PC_W-1:0] START_PC = '0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rcs_strobe_t      strobe,
  input  logic [PC_W-1:0]  cmdTarget,
  input  logic [PC_W-1:0]  cmdFallThru,
  input  logic [PC_W-1:0]  cmdPostDom,
  input  logic [LANES-1:0] takenMask,
  output logic [PC_W-1:0]  topPc,
  output logic [PC_W-1:0]  topRpc,
  output logic [LANES-1:0] topMask,
  output logic [PC_W-1:0]  belowPc,
  output logic             belowValid,
  output logic [CNT_W-1:0] stackDepth
);
  logic [PC_W-1:0]  pcMem   [DEPTH];
  logic [PC_W-1:0]  rpcMem  [DEPTH];
  logic [LANES-1:0] maskMem [DEPTH];
  logic [CNT_W-1:0] depthQ;

  logic [IDX_W-1:0] topIdx, belowIdx, reconSlot, ntSlot, tkSlot;
  logic [CNT_W-1:0] depthNext;
  logic topValid;

  always_comb begin
    topValid   = (depthQ != '0);
    belowValid = (int'(depthQ) >= 2);
    topIdx     = IDX_W'(int'(depthQ) - 1);
    belowIdx   = IDX_W'(int'(depthQ) - 2);
    reconSlot  = topIdx;
    ntSlot     = IDX_W'(int'(reconSlot) + int'(strobe.pushRecon));
    tkSlot     = IDX_W'(int'(ntSlot) + int'(strobe.pushNotTaken));
    depthNext  = CNT_W'(int'(depthQ) - int'(strobe.popTop) + int'(strobe.pushRecon)
                        + int'(strobe.pushNotTaken) + int'(strobe.pushTaken));
    topPc   = topValid ? pcMem[topIdx]   : '0;
    topRpc  = topValid ? rpcMem[topIdx]  : '0;
    topMask = topValid ? maskMem[topIdx] : '0;
    belowPc = belowValid ? pcMem[belowIdx] : '0;
  end

  assign stackDepth = depthQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        pcMem[i]   <= '0;
        rpcMem[i]  <= '0;
        maskMem[i] <= '0;
      end
      pcMem[0]   <= START_PC;
      rpcMem[0]  <= '1;
      maskMem[0] <= '1;
      depthQ     <= CNT_W'(1);
    end else if (strobe.commit) begin
      depthQ <= depthNext;
      if (strobe.replacePc) pcMem[topIdx] <= cmdTarget;
      if (strobe.pushRecon) begin
        pcMem[reconSlot]   <= cmdPostDom;
        rpcMem[reconSlot]  <= topRpc;
        maskMem[reconSlot] <= topMask;
      end
      if (strobe.pushNotTaken) begin
        pcMem[ntSlot]   <= cmdFallThru;
        rpcMem[ntSlot]  <= cmdPostDom;
        maskMem[ntSlot] <= topMask & ~takenMask;
      end
      if (strobe.pushTaken) begin
        pcMem[tkSlot]   <= cmdTarget;
        rpcMem[tkSlot]  <= cmdPostDom;
        maskMem[tkSlot] <= takenMask;
      end
    end
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_rcs_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  parameter logic [PC_W-1:0] START_PC = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  output logic                       cmdReady,
  input  logic                       cmdCond,
  input  logic [PC_W-1:0]            cmdTarget,
  input  logic [PC_W-1:0]            cmdFallThru,
  input  logic [PC_W-1:0]            cmdPostDom,
  input  logic [LANES-1:0]           cmdLaneCond,
  output logic [PC_W-1:0]            curPc,
  output logic [PC_W-1:0]            curRpc,
  output logic [LANES-1:0]           curMask,
  output logic [$clog2(LANES+1)-1:0] activeLanes,
  output logic [$clog2(DEPTH+1)-1:0] stackDepth,
  output logic                       overflowFlag,
  output logic                       underflowFlag,
  output logic                       branchErr
);
  rcs_strobe_t strobe;
  logic [LANES-1:0] takenMask;
  logic [PC_W-1:0] belowPc;
  logic belowValid;

  assign cmdReady = 1'b1;

  rcs_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCond(cmdCond),
    .cmdTarget(cmdTarget), .cmdFallThru(cmdFallThru), .cmdPostDom(cmdPostDom),
    .cmdLaneCond(cmdLaneCond), .topPc(curPc), .topRpc(curRpc), .topMask(curMask),
    .belowPc(belowPc), .belowValid(belowValid), .stackDepth(stackDepth),
    .strobe(strobe), .takenMask(takenMask), .topCount(activeLanes),
    .overflowQ(overflowFlag), .underflowQ(underflowFlag), .errQ(branchErr)
  );

  rcs_datapath #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START_PC)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdTarget(cmdTarget),
    .cmdFallThru(cmdFallThru), .cmdPostDom(cmdPostDom), .takenMask(takenMask),
    .topPc(curPc), .topRpc(curRpc), .topMask(curMask), .belowPc(belowPc),
    .belowValid(belowValid), .stackDepth(stackDepth)
  );
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cmdValid,
  input logic                       cmdReady,
  input logic                       cmdCond,
  input logic [PC_W-1:0]            cmdTarget,
  input logic [PC_W-1:0]            cmdFallThru,
  input logic [PC_W-1:0]            cmdPostDom,
  input logic [LANES-1:0]           cmdLaneCond,
  input logic [PC_W-1:0]            curPc,
  input logic [PC_W-1:0]            curRpc,
  input logic [LANES-1:0]           curMask,
  input logic [$clog2(LANES+1)-1:0] activeLanes,
  input logic [$clog2(DEPTH+1)-1:0] stackDepth,
  input logic                       overflowFlag,
  input logic                       underflowFlag,
  input logic                       branchErr
);
  logic warm;
  always_ff @(posedge clk) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(stackDepth) <= DEPTH);  // R8

  AST_OVERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (warm && overflowFlag) |-> (stackDepth == $past(stackDepth)));  // R8

  AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (warm && underflowFlag) |-> (stackDepth == '0 && $past(stackDepth) == '0));  // R9

  AST_UNCOND_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (warm && cmdValid && !cmdCond) |=>
      (stackDepth == $past(stackDepth) || int'(stackDepth) == int'($past(stackDepth)) - 1));  // R2

  AST_UNCOND_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (warm && cmdValid && !cmdCond && stackDepth != '0 && cmdTarget != curRpc) |=>
      (curPc == $past(cmdTarget) && curRpc == $past(curRpc) && curMask == $past(curMask)));  // R3

  AST_COND_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (warm && cmdValid && cmdCond) |=> (int'(stackDepth) <= int'($past(stackDepth)) + 2));  // R4

  AST_ERR_FROM_COND: assert property (@(posedge clk) disable iff (!rstN)
    (warm && branchErr) |-> $past(cmdValid && cmdCond));  // R7

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    int'(activeLanes) == $countones(curMask));  // R10

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stackDepth == '0) |-> (curMask == '0 && curPc == '0 && curRpc == '0));  // R10

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdReady);  // R11

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !cmdValid) |=> ($stable(stackDepth) && $stable(curPc) && !overflowFlag
                             && !underflowFlag && !branchErr));  // R11
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/simt_reconv_stack_tb_top.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb_top;
  localparam int LANES = 32;
  localparam int PC_W  = 32;
  localparam int DEPTH = 16;
  localparam logic [31:0] START = 32'h0000_0040;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdCond = 1'b0;
  logic [31:0] cmdTarget = '0, cmdFallThru = '0, cmdPostDom = '0, cmdLaneCond = '0;
  logic cmdReady;
  logic [31:0] curPc, curRpc, curMask;
  logic [5:0] activeLanes;
  logic [4:0] stackDepth;
  logic overflowFlag, underflowFlag, branchErr;

  always #4 clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START)) dut_i (.*);

  typedef struct { logic [31:0] pc; logic [31:0] rpc; logic [31:0] mask; } ent_t;
  ent_t stk[$];
  bit expOv, expUn, expErr;
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    ent_t t;
    if (stk.size() > 0) t = stk[stk.size()-1];
    else begin t.pc = 0; t.rpc = 0; t.mask = 0; end
    check(tag, "pc", curPc, t.pc);
    check(tag, "rpc", curRpc, t.rpc);
    check(tag, "mask", curMask, t.mask);
    check(tag, "activeLanes", activeLanes, $countones(t.mask));
    check(tag, "depth", stackDepth, stk.size());
    check(tag, "flags ov/un/err", {overflowFlag, underflowFlag, branchErr}, {expOv, expUn, expErr});
    check(tag, "ready", cmdReady, 1);
  endtask

  task automatic model(bit c, logic [31:0] tg, logic [31:0] ft, logic [31:0] pd, logic [31:0] lc);
    ent_t s, e;
    ent_t adds[$];
    logic [31:0] tk;
    expOv = 0; expUn = 0; expErr = 0;
    if (stk.size() == 0) begin expUn = 1; return; end
    s = stk[stk.size()-1];
    if (!c) begin
      if (tg == s.rpc) void'(stk.pop_back());
      else stk[stk.size()-1].pc = tg;
      return;
    end
    tk = lc & s.mask;
    if (s.rpc != pd) begin e.pc = pd; e.rpc = s.rpc; e.mask = s.mask; adds.push_back(e); end
    if (ft != pd && $countones(tk) < $countones(s.mask)) begin
      e.pc = ft; e.rpc = pd; e.mask = s.mask & ~tk; adds.push_back(e);
    end
    if (tg != pd && tk != 0) begin e.pc = tg; e.rpc = pd; e.mask = tk; adds.push_back(e); end
    if (stk.size() - 1 + adds.size() > DEPTH) begin expOv = 1; return; end
    void'(stk.pop_back());
    foreach (adds[i]) stk.push_back(adds[i]);
    expErr = (tg == ft) || (stk.size() > 0 && stk[stk.size()-1].pc == s.pc);
  endtask

  task automatic issue(string tag, bit c, logic [31:0] tg, logic [31:0] ft,
                       logic [31:0] pd, logic [31:0] lc);
    cmdValid = 1; cmdCond = c; cmdTarget = tg; cmdFallThru = ft; cmdPostDom = pd; cmdLaneCond = lc;
    model(c, tg, ft, pd, lc);
    @(negedge clk);
    cmdValid = 0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    expOv = 0; expUn = 0; expErr = 0;
    cmdTarget = $urandom; cmdCond = 1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic doReset();
    rstN = 0; cmdValid = 0;
    repeat (3) @(negedge clk);
    stk.delete();
    stk.push_back('{pc: START, rpc: 32'hFFFF_FFFF, mask: 32'hFFFF_FFFF});
    expOv = 0; expUn = 0; expErr = 0;
    rstN = 1;
    compare("R1");
  endtask

  function automatic logic [31:0] pickPc();
    case ($urandom_range(0, 5))
      0: return 32'h10; 1: return 32'h20; 2: return 32'h30;
      3: return 32'h40; 4: return 32'h50; default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  initial begin
    @(negedge clk);
    doReset();
    idle("R11");
    // R3: move top PC, keep rpc and mask
    issue("R3", 0, 32'h100, 0, 0, 0);
    // R4 R5 R6: split half/half, three pushes
    issue("R6", 1, 32'h200, 32'h104, 32'h300, 32'h0000_FFFF);
    // R2: taken path reaches join, pop to not-taken
    issue("R2", 0, 32'h300, 0, 0, 0);
    issue("R2", 0, 32'h300, 0, 0, 0);
    // R5: all lanes taken, not-taken push skipped
    issue("R5", 1, 32'h400, 32'h304, 32'h500, 32'hFFFF_FFFF);
    // R6: no lanes taken, taken push skipped; R4 recon skipped (rpc == postdom)
    issue("R4", 1, 32'h600, 32'h404, 32'h500, 32'h0);
    // R6: target equals post-dominator
    issue("R6", 1, 32'h500, 32'h408, 32'h500, 32'h00FF_00FF);
    idle("R11");
    // R7 errors
    doReset();
    issue("R7", 1, 32'h80, 32'h80, 32'h90, 32'hFFFF_FFFF);
    issue("R7", 1, 32'h80, 32'h84, 32'h90, 32'hFFFF_FFFF);
    idle("R7");
    // R8 overflow: each branch removes one lane, grows depth by two
    doReset();
    for (int i = 0; i < 9; i++) begin
      logic [31:0] m, b;
      m = stk[stk.size()-1].mask;
      b = 32'h1000 + i * 32'h40;
      issue("R8", 1, b, b + 4, b + 8, m & (m - 1));
    end
    idle("R8");
    // R9 underflow
    doReset();
    issue("R2", 0, 32'hFFFF_FFFF, 0, 0, 0);
    idle("R10");
    issue("R9", 0, 32'h44, 0, 0, 0);
    issue("R9", 1, 32'h44, 32'h48, 32'h4C, 32'hFFFF_FFFF);
    // random mix against the model
    doReset();
    for (int n = 0; n < 600; n++) begin
      if (stk.size() == 0) doReset();
      if ($urandom_range(0, 4) == 0) idle("R11");
      else if ($urandom_range(0, 2) == 0)
        issue("R3", 0, pickPc(), 0, 0, 0);
      else
        issue("R5", 1, pickPc(), pickPc(), pickPc(),
              ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom);
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule